// File: doc/BRIEF.md
# Floating-Point Compare with Status Update

This block compares two IEEE-754 binary floating-point operands (double precision by default) and reports how they relate. The result is a one-hot condition code: less, greater, equal, or unordered when either operand is a NaN. Alongside the code, the block takes the current value of a 32-bit floating-point status word and returns an updated copy that the status register owner writes back. The update places the condition code in its field, records that a NaN was seen, sets a sticky summary bit and, when the mode calls for it, raises the invalid-compare flag.

Two compare modes are selected per operation. The unordered mode only notes NaN inputs. The ordered mode also treats a NaN as an invalid operation. In that mode a signaling NaN always raises the invalid-compare flag. Quiet NaNs raise it only while the invalid-operation enable bit in the status word is clear.

The unit is pipelined and accepts one operation per clock. Results appear two cycles after the strobe.

Top module: `fcmp_unit`

## Requirements
- R1: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high, and is low otherwise. Synchronous active-high `rst` clears `out_valid`, `cc` and `stat_out` to zero.
- R2: `cc` is one-hot for every result: 4'b1000 when A < B, 4'b0100 when A > B, 4'b0010 when A == B, and 4'b0001 when the operands are unordered.
- R3: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. Any NaN operand gives `cc` = 4'b0001. An operand with an all-ones exponent and a zero fraction is an infinity and compares by value.
- R4: Ordered operands are ranked by numeric value. +0 and -0 compare equal, and of two negative operands the one with the larger magnitude is the smaller.
- R5: Status nibble k occupies bits [4k+3:4k]. `stat_out[15:12]` (nibble 3) equals the `cc` of the same result.
- R6: An unordered-mode compare with a NaN operand sets `stat_out[16]` (NaN seen, nibble 4 bit 0) and `stat_out[24]` (summary, nibble 6 bit 0).
- R7: An ordered-mode compare clears `stat_out[16]` when neither operand is a NaN and sets it when either operand is a NaN.
- R8: An ordered-mode compare in which an operand is a signaling NaN (fraction MSB 0) sets `stat_out[19]` (invalid-compare, nibble 4 bit 3). `stat_out[24]` passes through from `stat_in`.
- R9: An ordered-mode compare whose NaN operands are all quiet (fraction MSB 1) sets `stat_out[24]`. It also sets `stat_out[19]` when `stat_in[7]` (invalid enable, nibble 1 bit 3) is 0, and passes `stat_in[19]` through when that bit is 1.
- R10: Every status bit not named in R5 to R9 equals the corresponding bit of `stat_in` from the accepting cycle. Bits 16, 19 and 24 pass through in the cases where R6 to R9 leave them alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_ordered | input | 1 | 1 selects ordered compare, 0 selects unordered compare |
| op_a | input | 1+EXP_W+FRAC_W (64) | Operand A: sign, exponent, fraction |
| op_b | input | 1+EXP_W+FRAC_W (64) | Operand B |
| stat_in | input | STAT_W (32) | Current status word, sampled with the strobe |
| out_valid | output | 1 | Result strobe |
| cc | output | 4 | One-hot condition code |
| stat_out | output | STAT_W (32) | Updated status word to be written back |

## Verification
Every result (`out_valid`, `cc`, `stat_out`) is due two rising edges after the strobe: one register stage holds the operand classes and the magnitude compare, and a second holds the code and status word. The bench runs a reduced format with a 3-bit exponent and a 3-bit fraction. It sweeps every operand pair in both modes while varying the incoming status word, with idle cycles in between. Expected values travel through a two-entry shift structure in the bench, and each entry is compared with the outputs at the falling edge two cycles after it was driven.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int NIB_W       = 4;
  localparam int NIB_ENABLE  = 1;
  localparam int NIB_COND    = 3;
  localparam int NIB_EXC     = 4;
  localparam int NIB_SUMM    = 6;
  localparam int POS_INV_EN  = NIB_ENABLE * NIB_W + 3;
  localparam int POS_NAN_SEEN = NIB_EXC * NIB_W + 0;
  localparam int POS_INV_CMP = NIB_EXC * NIB_W + 3;
  localparam int POS_SUMM    = NIB_SUMM * NIB_W + 0;
  localparam int POS_COND    = NIB_COND * NIB_W;

  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0001;

  typedef struct packed {
    logic sign;
    logic zero;
    logic nan;
    logic snan;
  } opclass_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0]   op,
  output opclass_t                cls,
  output logic [EXP_W+FRAC_W-1:0] mag
);
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_max;
  logic              fr_nz;

  assign ex     = op[FRAC_W +: EXP_W];
  assign fr     = op[FRAC_W-1:0];
  assign ex_max = &ex;
  assign fr_nz  = |fr;
  assign mag    = op[EXP_W+FRAC_W-1:0];

  always_comb begin
    cls.sign = op[EXP_W+FRAC_W];
    cls.zero = ~(|ex) & ~fr_nz;
    cls.nan  = ex_max & fr_nz;
    cls.snan = ex_max & fr_nz & ~fr[FRAC_W-1];
  end
endmodule

// File: rtl/fcmp_magcmp.sv
module fcmp_magcmp #(
  parameter int M       = 63,
  parameter int CHUNK_W = 8
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         lt,
  output logic         eq
);
  localparam int NCH   = (M + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W = NCH * CHUNK_W;

  logic [PAD_W-1:0] pa;
  logic [PAD_W-1:0] pb;
  logic [NCH-1:0]   c_lt;
  logic [NCH-1:0]   c_eq;

  assign pa = PAD_W'(a);
  assign pb = PAD_W'(b);

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign c_lt[g] = pa[g*CHUNK_W +: CHUNK_W] <  pb[g*CHUNK_W +: CHUNK_W];
    assign c_eq[g] = pa[g*CHUNK_W +: CHUNK_W] == pb[g*CHUNK_W +: CHUNK_W];
  end

  // The most significant differing chunk decides.
  always_comb begin
    lt = 1'b0;
    eq = 1'b1;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eq && !c_eq[i]) begin
        lt = c_lt[i];
        eq = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcmp_status.sv
module fcmp_status
  import fcmp_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] stat_in,
  input  logic              ordered,
  input  logic [3:0]        cc,
  input  logic              any_snan,
  output logic [STAT_W-1:0] stat_nxt
);
  logic unord;
  assign unord = (cc == CC_UN);

  always_comb begin
    stat_nxt = stat_in;
    stat_nxt[POS_COND +: NIB_W] = cc;
    if (ordered) stat_nxt[POS_NAN_SEEN] = 1'b0;
    if (unord) begin
      stat_nxt[POS_NAN_SEEN] = 1'b1;
      if (!ordered) begin
        stat_nxt[POS_SUMM] = 1'b1;
      end else if (any_snan) begin
        stat_nxt[POS_INV_CMP] = 1'b1;
      end else begin
        stat_nxt[POS_SUMM] = 1'b1;
        if (!stat_in[POS_INV_EN]) stat_nxt[POS_INV_CMP] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int CHUNK_W = 8,
  parameter int STAT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_ordered,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic [STAT_W-1:0]       stat_in,
  output logic                    out_valid,
  output logic [3:0]              cc,
  output logic [STAT_W-1:0]       stat_out
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam int M = W - 1;
  localparam logic [STAT_W-1:0] TOUCHED =
      (STAT_W'(4'hF) << POS_COND) | (STAT_W'(1) << POS_NAN_SEEN) |
      (STAT_W'(1) << POS_INV_CMP) | (STAT_W'(1) << POS_SUMM);

  // Stage 0: operand classification and magnitude compare
  logic [W-1:0] ops [2];
  opclass_t     cls [2];
  logic [M-1:0] mag [2];
  logic         mag_lt, mag_eq;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[g]),
      .cls (cls[g]),
      .mag (mag[g])
    );
  end

  fcmp_magcmp #(.M(M), .CHUNK_W(CHUNK_W)) u_mag (
    .a  (mag[0]),
    .b  (mag[1]),
    .lt (mag_lt),
    .eq (mag_eq)
  );

  // Stage 1 registers
  logic              s1_vld, s1_ord, s1_lt, s1_eq;
  opclass_t          s1_a, s1_b;
  logic [STAT_W-1:0] s1_stat;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= in_valid;
    if (in_valid) begin
      s1_ord  <= in_ordered;
      s1_a    <= cls[0];
      s1_b    <= cls[1];
      s1_lt   <= mag_lt;
      s1_eq   <= mag_eq;
      s1_stat <= stat_in;
    end
  end

  // Stage 1 decision
  logic [3:0]        cc_nxt;
  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    if (s1_a.nan | s1_b.nan)        cc_nxt = CC_UN;
    else if (s1_a.zero & s1_b.zero) cc_nxt = CC_EQ;
    else if (s1_a.sign != s1_b.sign) cc_nxt = s1_a.sign ? CC_LT : CC_GT;
    else if (s1_eq)                 cc_nxt = CC_EQ;
    else if (s1_lt ^ s1_a.sign)     cc_nxt = CC_LT;
    else                            cc_nxt = CC_GT;
  end

  fcmp_status #(.STAT_W(STAT_W)) u_stat (
    .stat_in  (s1_stat),
    .ordered  (s1_ord),
    .cc       (cc_nxt),
    .any_snan (s1_a.snan | s1_b.snan),
    .stat_nxt (stat_nxt)
  );

  // Stage 2 output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cc        <= '0;
      stat_out  <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        cc       <= cc_nxt;
        stat_out <= stat_nxt;
      end
    end
  end

  // Checks
  p_lat_hi_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  p_lat_lo_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  p_cc_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(cc) == 1);
  p_cond_nib_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> stat_out[POS_COND +: NIB_W] == cc);
  p_nan_seen_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cc == CC_UN) |-> stat_out[POS_NAN_SEEN]);
  p_ord_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cc != CC_UN && $past(in_ordered, 2)) |-> !stat_out[POS_NAN_SEEN]);
  p_inv_cmp_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cc == CC_UN && $past(in_ordered, 2) && !$past(stat_in[POS_INV_EN], 2))
      |-> stat_out[POS_INV_CMP]);
  p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (stat_out & ~TOUCHED) == ($past(stat_in, 2) & ~TOUCHED));
endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  localparam int EW = 3;
  localparam int FW = 3;
  localparam int W  = 1 + EW + FW;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ordered = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic [SW-1:0] stat_in = '0;
  logic          out_valid;
  logic [3:0]    cc;
  logic [SW-1:0] stat_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fcmp_unit #(.EXP_W(EW), .FRAC_W(FW), .CHUNK_W(2), .STAT_W(SW)) u_fcmp_unit (
    .clk, .rst, .in_valid, .in_ordered, .op_a, .op_b, .stat_in,
    .out_valid, .cc, .stat_out
  );

  logic          pv  [2] = '{1'b0, 1'b0};
  logic [3:0]    pcc [2];
  logic [SW-1:0] pst [2];
  string         tcc [2];
  string         tst [2];

  function automatic void model(input logic ord, input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic [SW-1:0] st, output logic [3:0] c,
                                output logic [SW-1:0] s, output string tc, output string ts);
    logic na, nb, sa, sb;
    int ka, kb;
    na = (a[W-2 -: EW] == '1) && (a[FW-1:0] != 0);
    nb = (b[W-2 -: EW] == '1) && (b[FW-1:0] != 0);
    sa = na && !a[FW-1];
    sb = nb && !b[FW-1];
    ka = a[W-1] ? -int'(a[W-2:0]) : int'(a[W-2:0]);
    kb = b[W-1] ? -int'(b[W-2:0]) : int'(b[W-2:0]);
    s = st;
    if (na || nb) begin c = 4'b0001; tc = "R3"; end
    else if (ka < kb) begin c = 4'b1000; tc = "R2"; end
    else if (ka > kb) begin c = 4'b0100; tc = "R2"; end
    else begin c = 4'b0010; tc = "R4"; end
    s[15:12] = c;
    if (!(na || nb)) begin
      if (ord) s[16] = 1'b0;
      ts = ord ? "R7" : "R10";
    end else if (!ord) begin
      s[16] = 1'b1; s[24] = 1'b1; ts = "R6";
    end else if (sa || sb) begin
      s[16] = 1'b1; s[19] = 1'b1; ts = "R8";
    end else begin
      s[16] = 1'b1; s[24] = 1'b1;
      if (!st[7]) s[19] = 1'b1;
      ts = "R9";
    end
  endfunction

  task automatic check_outputs();
    checks++;
    if (out_valid !== pv[1]) begin
      errors++;
      $display("FAIL R1 out_valid actual %0b expected %0b", out_valid, pv[1]);
    end
    if (pv[1]) begin
      checks++;
      if (cc !== pcc[1]) begin
        errors++;
        $display("FAIL %s cc actual %b expected %b", tcc[1], cc, pcc[1]);
      end
      checks++;
      if (stat_out[15:12] !== pcc[1]) begin
        errors++;
        $display("FAIL R5 stat nibble3 actual %h expected %h", stat_out[15:12], pcc[1]);
      end
      checks++;
      if (stat_out !== pst[1]) begin
        errors++;
        $display("FAIL %s stat_out actual %h expected %h", tst[1], stat_out, pst[1]);
      end
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic v, input logic ord, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [SW-1:0] st);
    logic [3:0] c;
    logic [SW-1:0] s;
    string tc, ts;
    check_outputs();
    pv[1] = pv[0]; pcc[1] = pcc[0]; pst[1] = pst[0]; tcc[1] = tcc[0]; tst[1] = tst[0];
    model(ord, a, b, st, c, s, tc, ts);
    pv[0] = v; pcc[0] = c; pst[0] = s; tcc[0] = tc; tst[0] = ts;
    in_valid = v; in_ordered = ord; op_a = a; op_b = b; stat_in = st;
    @(negedge clk);
  endtask

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || cc !== 4'b0 || stat_out !== '0) begin
      errors++;
      $display("FAIL R1 reset actual %b/%b/%h expected 0/0/0", out_valid, cc, stat_out);
    end
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          step(1'b1, m[0], W'(a), W'(b), (idx * 32'h9E3779B1) ^ 32'h5A5AA5A5);
          idx++;
        end
        step(1'b0, 1'b0, '0, '0, '0); // idle cycle: R1 no result
      end
    end
    step(1'b0, 1'b0, '0, '0, '0);
    step(1'b0, 1'b0, '0, '0, '0);
    step(1'b0, 1'b0, '0, '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule